// File: doc/BRIEF.md
# Trigger Event Identifier Queue and Serialiser

This block runs on the bunch clock. It keeps two counters: an event number that advances on every level-1 accept, and a bunch-crossing number that advances on every clock. On each accept it takes a record of the current event number, the current bunch-crossing number and the 8-bit trigger type from its input. It writes that record into a small first-in first-out queue. The queue absorbs bursts of closely spaced accepts, because sending one record over the serial lines takes many clock cycles.

A serialiser takes the oldest record and sends it on two lines at the same time. The identifier line carries a 38-bit frame. The type line carries a 12-bit frame. Each frame opens with a start marker. The readout drivers that receive the lines need no framing signal other than that marker. An accept that finds the queue full is lost, and a sticky flag reports the loss.

Top module: `evid_serq_top`

## Requirements
- R1: On a clock cycle with `l1_accept` high, the block captures a record of the event number and the bunch-crossing number held in that cycle, together with `trig_type`. Records are sent in capture order.
- R2: The 24-bit event number advances by one after every accept, including an accept that is dropped. When `evt_cnt_clr` is high, the next value is 0. An accept in the same cycle as the clear still records the old value.
- R3: The 12-bit bunch-crossing number advances by one on every clock and wraps from 4095 to 0. When `bc_cnt_clr` is high, it reads 0 in the following cycle.
- R4: The identifier frame is 38 bits, one bit per clock. It starts with 1 and then 0. Next come the 24 event-number bits, least significant bit first, and then the 12 bunch-crossing bits, least significant bit first.
- R5: The type frame starts in the same cycle as the identifier frame. Its bits are 1, then 0, then the 8 type bits least significant first, then an even-parity bit over the type, then 0. The type line then holds 0 until the identifier frame ends.
- R6: Both lines hold 0 whenever no frame is being sent. At least one idle cycle separates two records.
- R7: The queue holds DEPTH records in addition to the record being sent. A record leaves the queue in the cycle its frames begin, which is one cycle after the serialiser becomes idle with a record waiting.
- R8: `q_full` is high exactly while DEPTH records are waiting.
- R9: An accept that arrives while `q_full` is high is dropped. It sets `q_overflow`, and the flag stays high until reset.
- R10: While `rst_n` is low, both lines and both flags are 0, and both counters clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l1_accept | input | 1 | Level-1 accept, one cycle per trigger |
| evt_cnt_clr | input | 1 | Event counter clear command |
| bc_cnt_clr | input | 1 | Bunch-crossing counter clear command |
| trig_type | input | 8 | Trigger type captured with each accept |
| id_line | output | 1 | Serial event-number and bunch-number frame |
| type_line | output | 1 | Serial trigger-type frame |
| q_full | output | 1 | Queue holds DEPTH waiting records |
| q_overflow | output | 1 | Sticky: an accept was dropped |

## Verification
The assertions assume that all inputs are known and stable at each rising clock edge after reset. They also assume that `l1_accept` and both clear commands mean one event per cycle in which they are high. The bench drives every input on the falling edge, so each value is settled a half period before the edge that samples it. In the random bursts, the gap after each burst is long enough for the queue to drain. An overflow therefore happens only in the one directed back-to-back burst, where the bench knows in advance which accepts must be lost.

// File: rtl/evid_pkg.sv
// Shared widths, frame lengths and the queued record type for the event
// identifier queue. Assumes frames are sent one bit per bunch clock.
package evid_pkg;
    localparam int EVN_W      = 24;
    localparam int BCN_W      = 12;
    localparam int TYP_W      = 8;
    localparam int MARK_W     = 2;
    localparam int ID_FRAME_W = MARK_W + EVN_W + BCN_W;
    localparam int TY_FRAME_W = MARK_W + TYP_W + 2;
    // Bit 0 leaves first: a 1, then a 0.
    localparam logic [MARK_W-1:0] START_MARK = 2'b01;

    typedef struct packed {
        logic [TYP_W-1:0] typ;
        logic [BCN_W-1:0] bcn;
        logic [EVN_W-1:0] evn;
    } evid_rec_t;

    localparam int REC_W = $bits(evid_rec_t);
endpackage

// File: rtl/evid_counters.sv
// Event and bunch-crossing counters. The event number advances on every
// accept and the bunch number on every clock. Each clear command overrides
// its counter's step. Assumes the commands are single-cycle and synchronous.
module evid_counters #(
    parameter int EVN_W = 24,
    parameter int BCN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             evn_clr,
    input  logic             bcn_clr,
    output logic [EVN_W-1:0] evn,
    output logic [BCN_W-1:0] bcn
);
    // Event number: clear wins, else step on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)       evn <= '0;
        else if (evn_clr) evn <= '0;
        else if (accept)  evn <= evn + 1'b1;
    end

    // Bunch-crossing number: clear wins, else step every clock (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n)       bcn <= '0;
        else if (bcn_clr) bcn <= '0;
        else              bcn <= bcn + 1'b1;
    end
endmodule

// File: rtl/evid_fifo.sv
// Record queue of DEPTH entries with first-word fall-through output. A push
// while full is ignored; the caller flags it. Pop is only valid when not empty.
module evid_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/evid_lane.sv
// One serial lane: loads a whole frame and shifts it out LSB first, filling
// with zeros. Assumes load and shift are never used for two purposes at once.
module evid_lane #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift,
    output logic               ser_out
);
    logic [FRAME_W-1:0] sh;

    // Frame register: load, else shift right by one.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh <= '0;
        else if (load)  sh <= frame;
        else if (shift) sh <= {1'b0, sh[FRAME_W-1:1]};
    end

    assign ser_out = sh[0];
endmodule

// File: rtl/evid_frame_ser.sv
// Builds both frames from one record and sends them in lock-step. The shared
// bit counter is sized to the longer (identifier) frame, and the shorter
// lane runs out as zeros. Assumes load arrives only while not busy.
module evid_frame_ser
    import evid_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  evid_rec_t rec,
    output logic      busy,
    output logic      id_line,
    output logic      type_line
);
    localparam int CNT_W = $clog2(ID_FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ID_FRAME_W - 1);

    logic [CNT_W-1:0]      bit_idx;
    logic [ID_FRAME_W-1:0] id_frame;
    logic [TY_FRAME_W-1:0] ty_frame;
    logic                  id_bit, ty_bit, step;

    // Frame images: marker first, fields LSB first, parity then a 0 on type.
    always_comb begin
        id_frame = {rec.bcn, rec.evn, START_MARK};
        ty_frame = {1'b0, ^rec.typ, rec.typ, START_MARK};
    end

    // Frame timing: busy for exactly ID_FRAME_W cycles after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (busy) begin
            if (bit_idx == LAST_BIT) busy <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign step = busy && !load;

    evid_lane #(.FRAME_W(ID_FRAME_W)) u_id_lane (
        .clk(clk), .rst_n(rst_n), .load(load), .frame(id_frame),
        .shift(step), .ser_out(id_bit)
    );

    evid_lane #(.FRAME_W(TY_FRAME_W)) u_ty_lane (
        .clk(clk), .rst_n(rst_n), .load(load), .frame(ty_frame),
        .shift(step), .ser_out(ty_bit)
    );

    assign id_line   = busy & id_bit;
    assign type_line = busy & ty_bit;
endmodule

// File: rtl/evid_serq_top.sv
// Event identifier queue and serialiser top. It captures a record on each
// accept, queues up to DEPTH records, and streams them on two serial lines.
// Assumes every input is synchronous to the bunch clock.
module evid_serq_top
    import evid_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1_accept,
    input  logic             evt_cnt_clr,
    input  logic             bc_cnt_clr,
    input  logic [TYP_W-1:0] trig_type,
    output logic             id_line,
    output logic             type_line,
    output logic             q_full,
    output logic             q_overflow
);
    logic [EVN_W-1:0] evn_now;
    logic [BCN_W-1:0] bcn_now;
    evid_rec_t        rec_in;
    logic [REC_W-1:0] q_dout;
    logic             q_empty, ser_busy, rec_load;

    evid_counters #(.EVN_W(EVN_W), .BCN_W(BCN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .accept(l1_accept),
        .evn_clr(evt_cnt_clr), .bcn_clr(bc_cnt_clr),
        .evn(evn_now), .bcn(bcn_now)
    );

    // Record image as seen in the accept cycle.
    always_comb begin
        rec_in.typ = trig_type;
        rec_in.bcn = bcn_now;
        rec_in.evn = evn_now;
    end

    evid_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_q (
        .clk(clk), .rst_n(rst_n), .push(l1_accept), .din(rec_in),
        .pop(rec_load), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    assign rec_load = !ser_busy && !q_empty;

    evid_frame_ser u_ser (
        .clk(clk), .rst_n(rst_n), .load(rec_load), .rec(evid_rec_t'(q_dout)),
        .busy(ser_busy), .id_line(id_line), .type_line(type_line)
    );

    // Sticky loss flag: set by an accept that meets a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                   q_overflow <= 1'b0;
        else if (l1_accept && q_full) q_overflow <= 1'b1;
    end
endmodule

// File: rtl/evid_serq_chk.sv
// Property checker for evid_serq_top, bound to every instance of it.
module evid_serq_chk
    import evid_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             l1_accept,
    input logic             evt_cnt_clr,
    input logic             bc_cnt_clr,
    input logic             id_line,
    input logic             type_line,
    input logic             q_full,
    input logic             q_overflow,
    input logic [EVN_W-1:0] evn_now,
    input logic [BCN_W-1:0] bcn_now,
    input logic             ser_busy,
    input logic             rec_load
);
    a_r2_ev_clear: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cnt_clr |=> evn_now == '0);
    a_r2_ev_step: assert property (@(posedge clk) disable iff (!rst_n)
        l1_accept && !evt_cnt_clr |=> evn_now == EVN_W'($past(evn_now) + 1));
    a_r2_ev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_accept && !evt_cnt_clr |=> $stable(evn_now));
    a_r3_bc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bc_cnt_clr |=> bcn_now == '0);
    a_r3_bc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_cnt_clr |=> bcn_now == BCN_W'($past(bcn_now) + 1));
    a_r5_start_one: assert property (@(posedge clk) disable iff (!rst_n)
        rec_load |=> id_line && type_line);
    a_r5_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rec_load |=> ##1 (!id_line && !type_line));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_busy |-> !id_line && !type_line);
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ser_busy |-> !rec_load);
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && !rec_load |=> q_full);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q_overflow |=> q_overflow);
    a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_overflow) |-> $past(l1_accept && q_full));
endmodule

bind evid_serq_top evid_serq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept),
    .evt_cnt_clr(evt_cnt_clr), .bc_cnt_clr(bc_cnt_clr),
    .id_line(id_line), .type_line(type_line), .q_full(q_full),
    .q_overflow(q_overflow), .evn_now(evn_now), .bcn_now(bcn_now),
    .ser_busy(ser_busy), .rec_load(rec_load)
);

// File: tb/sim_evid_serq_top.sv
module sim_evid_serq_top;
    localparam int CLK_NS = 8;
    localparam int DEPTH  = 8;
    localparam int MAXR   = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l1_accept = 1'b0, evt_cnt_clr = 1'b0, bc_cnt_clr = 1'b0;
    logic [7:0] trig_type = '0;
    logic       id_line, type_line, q_full, q_overflow;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    evid_serq_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept),
        .evt_cnt_clr(evt_cnt_clr), .bc_cnt_clr(bc_cnt_clr),
        .trig_type(trig_type), .id_line(id_line), .type_line(type_line),
        .q_full(q_full), .q_overflow(q_overflow)
    );

    // Bench-side model state and expected/decoded record lists.
    logic [23:0] m_ev = '0;
    logic [11:0] m_bc = '0;
    logic [23:0] e_evn [MAXR];
    logic [11:0] e_bcn [MAXR];
    logic [7:0]  e_typ [MAXR];
    string       e_tag [MAXR];
    int          n_exp = 0;
    logic [37:0] d_id [MAXR];
    logic [11:0] d_ty [MAXR];
    int          n_dec = 0;

    function automatic logic [37:0] f_id(logic [23:0] e, logic [11:0] b);
        return {b, e, 2'b01};
    endfunction

    function automatic logic [11:0] f_ty(logic [7:0] t);
        return {1'b0, ^t, t, 2'b01};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge; updates the model.
    task automatic drive(logic acc, logic ecr, logic bcr, logic [7:0] ty,
                         logic keep, string tag);
        l1_accept = acc; evt_cnt_clr = ecr; bc_cnt_clr = bcr; trig_type = ty;
        if (acc && keep) begin
            e_evn[n_exp] = m_ev; e_bcn[n_exp] = m_bc;
            e_typ[n_exp] = ty;   e_tag[n_exp] = tag;
            n_exp++;
        end
        m_bc = bcr ? 12'd0 : m_bc + 12'd1;
        m_ev = ecr ? 24'd0 : (acc ? m_ev + 24'd1 : m_ev);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 0, "");
    endtask

    // Line decoder: finds start markers and collects both frames.
    int          dcnt = -1;
    bit          need_gap = 0, tail_bad = 0;
    logic [37:0] acc_id;
    logic [11:0] acc_ty;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dcnt < 0) begin
                if (need_gap) begin
                    check("R6 idle gap", {id_line, type_line}, 2'b00);
                    need_gap = 0;
                end else if (id_line || type_line) begin
                    check("R5 frames start together", {id_line, type_line}, 2'b11);
                    acc_id = '0; acc_ty = '0; tail_bad = 0;
                    acc_id[0] = id_line; acc_ty[0] = type_line;
                    dcnt = 1;
                end
            end else begin
                acc_id[dcnt] = id_line;
                if (dcnt < 12) acc_ty[dcnt] = type_line;
                else if (type_line) tail_bad = 1;
                dcnt++;
                if (dcnt == 38) begin
                    check("R5 type line tail zero", tail_bad, 1'b0);
                    if (n_dec < MAXR) begin
                        d_id[n_dec] = acc_id; d_ty[n_dec] = acc_ty;
                    end
                    n_dec++;
                    dcnt = -1; need_gap = 1;
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R10: quiet outputs during reset.
        check("R10 id_line in reset", id_line, 1'b0);
        check("R10 type_line in reset", type_line, 1'b0);
        check("R10 q_full in reset", q_full, 1'b0);
        check("R10 q_overflow in reset", q_overflow, 1'b0);
        rst_n = 1'b1;

        // First record after reset: counters from 0.
        idle(3);
        drive(1, 0, 0, 8'hA5, 1, "R10 R2 R4");
        idle(50);
        // R2: clear with accept keeps old value; next accept is 0.
        drive(1, 0, 0, 8'h01, 1, "R1 R4");
        idle(45);
        drive(1, 1, 0, 8'h80, 1, "R2 R4");
        idle(45);
        drive(1, 0, 0, 8'h7F, 1, "R2 R4");
        drive(0, 1, 0, 8'h00, 0, "");
        idle(45);
        drive(1, 0, 0, 8'h00, 1, "R2 R4");
        idle(45);
        // R3: bunch clear, then accept 7 cycles later; clear with accept.
        drive(0, 0, 1, 8'h00, 0, "");
        idle(6);
        drive(1, 0, 0, 8'hFF, 1, "R3 R4");
        idle(45);
        drive(1, 0, 1, 8'h3C, 1, "R3 R4");
        idle(45);
        // R3: wrap past 4095 with no clear.
        idle(4100);
        drive(1, 0, 0, 8'h5A, 1, "R3 R4");
        idle(60);

        // Random bursts short enough to drain in each gap.
        for (int b = 0; b < 30; b++) begin
            int len = $urandom_range(1, 6);
            for (int k = 0; k < len; k++) begin
                int sp = $urandom_range(0, 3);
                for (int s = 0; s < sp; s++)
                    drive(0, $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                          8'h00, 0, "");
                drive(1, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                      8'($urandom), 1, "R1 R4 R7");
            end
            idle(260);
        end
        check("R9 no overflow in bounded bursts", q_overflow, 1'b0);
        check("R6 lines idle after drain", {id_line, type_line}, 2'b00);
        check("R8 not full after drain", q_full, 1'b0);

        // Back-to-back burst of 12: one in flight + DEPTH queued, rest lost.
        for (int k = 0; k < 12; k++)
            drive(1, 0, 0, 8'(8'h10 + k), k < DEPTH + 1, "R7 R9 R4");
        check("R8 full after burst", q_full, 1'b1);
        check("R9 overflow after burst", q_overflow, 1'b1);
        idle(420);
        check("R8 full clears on drain", q_full, 1'b0);
        check("R9 overflow sticky", q_overflow, 1'b1);
        drive(1, 0, 0, 8'hC3, 1, "R2 R9 R4");
        idle(60);

        check("R7 record count", n_dec, n_exp);
        for (int i = 0; i < n_exp && i < n_dec && i < MAXR; i++) begin
            check(e_tag[i], d_id[i], f_id(e_evn[i], e_bcn[i]));
            check("R1 R5 type frame", d_ty[i], f_ty(e_typ[i]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule